// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the read/write command strobe for one IDE channel that serves two drives. Each drive has a 16-bit control word. The word gives the asserted time and the recovery time of the strobe as cycle counts, each stored minus one, plus a bit that turns on IORDY wait-state stretching. The clock is taken as 30 ns, so every timing is a whole number of clock cycles.

A channel-level wide-timing bit selects between the drive's programmed timing and a fixed slowest-mode (PIO0) timing. The block accepts a request with a drive number only when it is idle. It raises the strobe for the asserted phase and holds it low for the recovery phase. It then gives a one-cycle done pulse. The data path and the bus-master engine are handled elsewhere.

Top module: `ide_pio_strobe_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `strobe`, `busy` and `done` are low.
- R2: With `wide_timing` high, a request accepted at a clock edge raises `strobe` in the following cycle and keeps it high for (word[15:8] + 1) cycles. `busy` is high throughout. The multiword DMA words 0x0707, 0x0201 and 0x0200 give 8, 3 and 3 asserted cycles.
- R3: After the asserted phase, `strobe` is low and `busy` is high for (word[5:0] + 1) recovery cycles.
- R4: A stored field of zero gives exactly one asserted cycle, or exactly one recovery cycle.
- R5: With `wide_timing` low, every transfer uses 6 asserted and 14 recovery cycles. The drive word is ignored, including its IORDY bit.
- R6: `req_drive` = 0 selects `drive_ctrl[15:0]` and `req_drive` = 1 selects `drive_ctrl[31:16]`.
- R7: With word bit 6 set, the strobe is released only at a clock edge where the count has run out and `iordy` is sampled high. The asserted time is therefore max(count, first high IORDY sample after acceptance).
- R8: With word bit 6 clear, a low `iordy` has no effect on the timing.
- R9: `done` is high for exactly one cycle. That cycle immediately follows the last recovery cycle, and in it `busy` is low.
- R10: A request raised while `busy` is high is ignored. It does not extend the transfer and does not start another one after `done`.
- R11: The timing is captured when the request is accepted. Changes to `drive_ctrl`, `wide_timing` or `req_drive` during a transfer do not affect it.
- R12: `strobe` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle counts as 30 ns |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request, taken only when idle |
| req_drive | input | 1 | Drive number for the request |
| drive_ctrl | input | 32 | Control words of both drives, drive 0 in the low half |
| wide_timing | input | 1 | 1: programmed timing, 0: fixed PIO0 timing |
| iordy | input | 1 | Drive ready pin, low asks for wait states |
| strobe | output | 1 | Command strobe, high while asserted |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after recovery ends |

## Verification
The bench goes after off-by-one errors in the stored fields. These show up as a zero field giving no cycle or two cycles, or as each DMA word giving the wrong strobe width. It stalls IORDY both past and inside the asserted count. A design that sampled IORDY while the enable bit was clear, or honoured the enable in PIO0, would stretch the strobe. A design that failed to wait would release it early. It also changes the control words and raises a second request during a transfer. This exposes designs that read the timing live or re-trigger after done.

// File: rtl/ide_strobe_pkg.sv
`timescale 1ns/1ps
package ide_strobe_pkg;

    localparam int CTRL_W    = 16;
    localparam int ON_LSB    = 8;
    localparam int ON_W      = 8;
    localparam int REC_W     = 6;
    localparam int IORDY_BIT = 6;
    localparam int CNT_W     = (ON_W > REC_W) ? ON_W : REC_W;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACTIVE  = 2'd1,
        PH_RECOVER = 2'd2
    } phase_e;

    // One set of strobe timing, counts stored minus one
    typedef struct packed {
        logic [ON_W-1:0]  on_m1;
        logic [REC_W-1:0] rec_m1;
        logic             iordy_en;
    } timing_t;

endpackage

// File: rtl/ide_timing_sel.sv
`timescale 1ns/1ps
module ide_timing_sel
    import ide_strobe_pkg::*;
#(
    parameter int NUM_DRIVES   = 2,
    parameter int PIO0_ON_CYC  = 6,
    parameter int PIO0_REC_CYC = 14,
    localparam int DSEL_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic [NUM_DRIVES*CTRL_W-1:0] drive_ctrl,
    input  logic [DSEL_W-1:0]            drive_sel,
    input  logic                         wide_timing,
    output timing_t                      tim
);

    timing_t per_drive [NUM_DRIVES];
    logic [NUM_DRIVES-1:0] unused_rsvd;

    // Decode each drive word into its timing fields
    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_decode
        logic [CTRL_W-1:0] word;
        assign word                 = drive_ctrl[d*CTRL_W +: CTRL_W];
        assign per_drive[d].on_m1   = word[ON_LSB +: ON_W];
        assign per_drive[d].rec_m1  = word[REC_W-1:0];
        assign per_drive[d].iordy_en = word[IORDY_BIT];
        assign unused_rsvd[d]       = word[IORDY_BIT+1];
    end

    localparam timing_t PIO0_TIM = '{
        on_m1:    ON_W'(PIO0_ON_CYC - 1),
        rec_m1:   REC_W'(PIO0_REC_CYC - 1),
        iordy_en: 1'b0
    };

    always_comb begin
        if (wide_timing) begin
            tim = per_drive[drive_sel];
        end else begin
            tim = PIO0_TIM;
        end
    end

endmodule

// File: rtl/ide_strobe_fsm.sv
`timescale 1ns/1ps
module ide_strobe_fsm
    import ide_strobe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  timing_t tim,
    input  logic    iordy,
    output logic    strobe,
    output logic    busy,
    output logic    done
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [REC_W-1:0] rec_m1;
        logic             iordy_en;
        logic             done;
    } state_t;

    localparam state_t RESET_ST = '{
        phase:    PH_IDLE,
        cnt:      '0,
        rec_m1:   '0,
        iordy_en: 1'b0,
        done:     1'b0
    };

    state_t st_d, st_q;
    logic   count_out;
    logic   wait_req;

    assign count_out = (st_q.cnt == '0);
    assign wait_req  = st_q.iordy_en && !iordy;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase    = PH_ACTIVE;
                    st_d.cnt      = CNT_W'(tim.on_m1);
                    st_d.rec_m1   = tim.rec_m1;
                    st_d.iordy_en = tim.iordy_en;
                end
            end
            PH_ACTIVE: begin
                if (!count_out) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else if (!wait_req) begin
                    st_d.phase = PH_RECOVER;
                    st_d.cnt   = CNT_W'(st_q.rec_m1);
                end
            end
            PH_RECOVER: begin
                if (!count_out) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d = RESET_ST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = (st_q.phase == PH_ACTIVE);
    assign busy   = (st_q.phase != PH_IDLE);
    assign done   = st_q.done;

endmodule

// File: rtl/ide_pio_strobe_gen.sv
`timescale 1ns/1ps
module ide_pio_strobe_gen
    import ide_strobe_pkg::*;
#(
    parameter int NUM_DRIVES   = 2,
    parameter int PIO0_ON_CYC  = 6,
    parameter int PIO0_REC_CYC = 14,
    localparam int DSEL_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [DSEL_W-1:0]            req_drive,
    input  logic [NUM_DRIVES*CTRL_W-1:0] drive_ctrl,
    input  logic                         wide_timing,
    input  logic                         iordy,
    output logic                         strobe,
    output logic                         busy,
    output logic                         done
);

    timing_t sel_tim;

    ide_timing_sel #(
        .NUM_DRIVES   (NUM_DRIVES),
        .PIO0_ON_CYC  (PIO0_ON_CYC),
        .PIO0_REC_CYC (PIO0_REC_CYC)
    ) sel_i (
        .drive_ctrl  (drive_ctrl),
        .drive_sel   (req_drive),
        .wide_timing (wide_timing),
        .tim         (sel_tim)
    );

    ide_strobe_fsm fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (req_valid),
        .tim    (sel_tim),
        .iordy  (iordy),
        .strobe (strobe),
        .busy   (busy),
        .done   (done)
    );

endmodule

// File: rtl/ide_pio_strobe_gen_chk.sv
`timescale 1ns/1ps
module ide_pio_strobe_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic strobe,
    input logic busy,
    input logic done
);

    p_strobe_needs_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> busy);

    p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (strobe && busy));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_ends_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_recovery_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> busy);

endmodule

bind ide_pio_strobe_gen ide_pio_strobe_gen_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
);

// File: tb/ide_pio_strobe_gen_tb.sv
`timescale 1ns/1ps
module ide_pio_strobe_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [0:0]  req_drive = 1'b0;
    logic [31:0] drive_ctrl = '0;
    logic        wide_timing = 1'b0;
    logic        iordy = 1'b1;
    logic        strobe, busy, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ide_pio_strobe_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_drive   (req_drive),
        .drive_ctrl  (drive_ctrl),
        .wide_timing (wide_timing),
        .iordy       (iordy),
        .strobe      (strobe),
        .busy        (busy),
        .done        (done)
    );

    // Behavioural reference: 0 idle, 1 asserted, 2 recovery
    int m_phase = 0;
    int m_left  = 0;
    int m_rec   = 0;
    bit m_wait  = 0;
    bit m_done  = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_phase == 0) begin
                if (req_valid) begin
                    logic [15:0] w;
                    w = req_drive[0] ? drive_ctrl[31:16] : drive_ctrl[15:0];
                    if (wide_timing) begin
                        m_left = int'(w[15:8]) + 1;
                        m_rec  = int'(w[5:0]) + 1;
                        m_wait = w[6];
                    end else begin
                        m_left = 6; m_rec = 14; m_wait = 0;
                    end
                    m_phase = 1;
                end
            end else if (m_phase == 1) begin
                if (m_left > 1) m_left--;
                else if (!(m_wait && !iordy)) begin
                    m_phase = 2; m_left = m_rec;
                end
            end else begin
                if (m_left > 1) m_left--;
                else begin
                    m_phase = 0; m_done = 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    bit compare_on = 1'b0;
    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            check(strobe == (m_phase == 1), "R2 R3 model strobe", int'(strobe), int'(m_phase == 1));
            check(busy == (m_phase != 0), "R3 R10 model busy", int'(busy), int'(m_phase != 0));
            check(done == m_done, "R9 model done", int'(done), int'(m_done));
            check(!(strobe && !busy), "R12 strobe without busy", int'(strobe), 0);
        end
    end

    task automatic xfer(input bit drv, input bit wide, input logic [15:0] c0,
                        input logic [15:0] c1, input int stall, input bit disturb,
                        input string tag, input int exp_hi, input int exp_lo);
        int hi = 0;
        int lo = 0;
        bit got = 0;
        int idle_busy = 0;
        @(negedge clk);
        drive_ctrl  = {c1, c0};
        req_drive   = drv;
        wide_timing = wide;
        req_valid   = 1'b1;
        iordy       = (stall == 0);
        for (int k = 1; k < 3000 && !got; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (k == stall) iordy = 1'b1;
            if (disturb && k == 3) begin
                drive_ctrl  = ~{c1, c0};
                wide_timing = ~wide;
                req_drive   = ~drv;
                req_valid   = 1'b1;
            end
            if (disturb && k == 4) req_valid = 1'b0;
            if (strobe) hi++;
            else if (busy) lo++;
            if (done) got = 1;
        end
        iordy = 1'b1;
        check(got, {tag, " done seen"}, int'(got), 1);
        check(hi == exp_hi, {tag, " asserted cycles"}, hi, exp_hi);
        check(lo == exp_lo, {tag, " recovery cycles"}, lo, exp_lo);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (busy || strobe) idle_busy++;
        end
        check(idle_busy == 0, {tag, " R10 stays idle"}, idle_busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!strobe && !busy && !done, "R1 during reset", int'({strobe, busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!strobe && !busy && !done, "R1 after reset", int'({strobe, busy, done}), 0);
        compare_on = 1'b1;

        xfer(0, 1, 16'h0305, 16'h0000, 0, 0, "R2 R3 drive0", 4, 6);
        xfer(1, 1, 16'h0101, 16'h0A02, 0, 0, "R6 drive1", 11, 3);
        xfer(0, 1, 16'h0101, 16'h0A02, 0, 0, "R6 drive0", 2, 2);
        xfer(0, 1, 16'h0000, 16'hFFFF, 0, 0, "R4 zero fields", 1, 1);
        xfer(0, 1, 16'h0707, 16'h0000, 0, 0, "R2 dma word0", 8, 8);
        xfer(1, 1, 16'h0000, 16'h0201, 0, 0, "R2 dma word1", 3, 2);
        xfer(0, 1, 16'h0200, 16'h0000, 0, 0, "R2 dma word2", 3, 1);
        xfer(0, 1, 16'hFF3F, 16'h0000, 0, 0, "R2 R3 max fields", 256, 64);
        xfer(0, 0, 16'h0345, 16'h0000, 10, 0, "R5 pio0 fallback", 6, 14);
        xfer(1, 0, 16'h0000, 16'h0000, 0, 0, "R5 pio0 drive1", 6, 14);
        xfer(0, 1, 16'h0343, 16'h0000, 9, 0, "R7 long stall", 9, 4);
        xfer(0, 1, 16'h0343, 16'h0000, 2, 0, "R7 short stall", 4, 4);
        xfer(0, 1, 16'h0043, 16'h0000, 5, 0, "R7 R4 stall one-cycle", 5, 4);
        xfer(0, 1, 16'h0303, 16'h0000, 9, 0, "R8 iordy ignored", 4, 4);
        xfer(0, 1, 16'h0202, 16'h0505, 0, 1, "R11 R10 disturb", 3, 3);
        xfer(1, 0, 16'h0000, 16'h0000, 0, 1, "R11 R5 disturb pio0", 6, 14);

        compare_on = 1'b0;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule